// File: doc/BRIEF.md
# Answer-to-Reset Serial Streamer

This block lets a selected serial memory device answer a reset pulse with a fixed 32-bit identification word. It needs no start condition. The host holds chip select low and pulses the dedicated reset pin high. When that pin falls again, the block drives the lowest bit of the word onto the serial data line. Each later falling edge of the serial clock moves the line on to the next bit. After the last bit the block lets go of the line.

The stored word comes from a register input. The block takes a snapshot of it when the stream starts. A reset pulse is refused while an internal write is busy, and a stream stops at once when chip select rises. A reset pulse held high for longer than `RST_MAX_CYC` system clocks is treated as a protocol violation. No answer follows it.

The block does not drive a pad itself. It gives out a data bit and a drive enable, plus an ownership flag. The ordinary serial slave that shares the pad uses the flag to keep its own driver off.

All control inputs are asynchronous to the system clock and pass through synchronisers.

Top module: `atr_streamer`

## Requirements
- R1: After system reset, `sda_oe` and `atr_own` are 0.
- R2: A rising edge on `card_rst` while `cs_n` is 0 and `wr_busy` is 0 sets `atr_own` to 1 and leaves `sda_oe` at 0 while `card_rst` stays high. When `card_rst` falls, `sda_oe` goes to 1 and `sda_o` presents bit 0 of `atr_word`.
- R3: Bits leave least significant first. After the k-th falling edge of `scl` within a stream, `sda_o` equals bit k of the word, for k from 1 to 31.
- R4: The 32nd falling edge of `scl` within a stream returns both `sda_oe` and `atr_own` to 0.
- R5: A `card_rst` rising edge seen while `wr_busy` is 1 starts nothing. Both outputs stay 0 through the pulse, after its fall, and across later `scl` edges.
- R6: If `cs_n` goes to 1 while `atr_own` is 1, both outputs drop to 0. Nothing more is sent after `cs_n` returns to 0, even if `scl` keeps toggling.
- R7: A `card_rst` rising edge while `cs_n` is 1 is ignored. This includes the case where `cs_n` falls while `card_rst` is still high and `card_rst` then falls.
- R8: If `card_rst` stays high for more than `RST_MAX_CYC` clock cycles, `atr_own` drops to 0 and no bit is sent when the pin falls. A proper pulse after that works normally.
- R9: A `card_rst` pulse during a running stream is ignored. The stream continues with the next bit in order and no restart occurs.
- R10: Changes to `atr_word` after the stream has started do not alter the bits sent.
- R11: Falling edges of `scl` while `card_rst` is still high do not advance the bit position. The first bit sent is still bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| card_rst | input | 1 | Reset pin from the host, active high pulse |
| cs_n | input | 1 | Chip select, active low |
| scl | input | 1 | Serial clock from the host |
| wr_busy | input | 1 | High while an internal nonvolatile write runs |
| atr_word | input | WORD_W | Word to be streamed, bit 0 first |
| sda_o | output | 1 | Data bit for the shared pad |
| sda_oe | output | 1 | Pad drive enable, 1 while a bit is presented |
| atr_own | output | 1 | Ownership flag, tells the serial slave to release the pad |

## Verification
The assertions assume that the host pins change slowly compared with the system clock. Each level must last well beyond the synchroniser depth, so that every edge of `card_rst` and `scl` is seen exactly once. The stimulus holds each `scl` and `card_rst` level for at least six system clocks. It only samples outputs eight clocks after a pin change, once the synchronisers and one register stage have settled. `atr_word` is assumed stable from the `card_rst` falling edge until the snapshot is taken. The bench changes it only mid-stream, and only to test that the snapshot ignores it.

// File: rtl/atr_pkg.sv
package atr_pkg;
  localparam int unsigned ATR_WORD_W   = 32;
  localparam int unsigned ATR_SYNC_STG = 2;
  localparam int unsigned ATR_RST_MAX  = 200;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_STREAM = 2'd2,
    SEQ_HOLD   = 2'd3
  } atr_seq_e;
endpackage

// File: rtl/atr_rstsync.sv
module atr_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_sn = rs_q[1];
endmodule

// File: rtl/atr_sync.sv
module atr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic [WIDTH-1:0] d,
  input  logic [WIDTH-1:0] rst_val,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_sn) begin
          if (!rst_sn) stg_q[s] <= rst_val;
          else         stg_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_sn) begin
          if (!rst_sn) stg_q[s] <= rst_val;
          else         stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/atr_seq.sv
module atr_seq
  import atr_pkg::*;
#(
  parameter int unsigned RST_MAX_CYC = ATR_RST_MAX
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic rst_s,
  input  logic cs_s,
  input  logic busy_s,
  input  logic done,
  output logic start,
  output logic own
);
  localparam int unsigned CNT_W = $clog2(RST_MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(RST_MAX_CYC);

  atr_seq_e          state_q, state_d;
  logic              rst_d_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic              rst_rise, rst_fall;

  assign rst_rise = rst_s & ~rst_d_q;
  assign rst_fall = ~rst_s & rst_d_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    start   = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (rst_rise && !cs_s && !busy_s) begin
          state_d = SEQ_ARMED;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      SEQ_ARMED: begin
        if (cs_s) begin
          state_d = SEQ_IDLE;
        end else if (rst_fall) begin
          state_d = SEQ_STREAM;
          start   = 1'b1;
        end else if (cnt_q == CNT_LIM) begin
          state_d = SEQ_HOLD;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      SEQ_STREAM: begin
        if (cs_s || done) state_d = SEQ_IDLE;
      end
      SEQ_HOLD: begin
        if (!rst_s) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= SEQ_IDLE;
      rst_d_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_d_q <= rst_s;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign own = (state_q == SEQ_ARMED) || (state_q == SEQ_STREAM);

  // R5
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == SEQ_IDLE && busy_s) |=> (state_q != SEQ_ARMED));

  // R8
  pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == SEQ_ARMED) |-> (cnt_q <= CNT_LIM));

  // R8
  hold_silent_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == SEQ_HOLD) |=> (state_q != SEQ_STREAM));
endmodule

// File: rtl/atr_shift.sv
module atr_shift #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              scl_s,
  input  logic              start,
  input  logic              abort,
  input  logic [WORD_W-1:0] word_in,
  output logic              done,
  output logic              active,
  output logic              bit_out
);
  localparam int unsigned IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

  logic              active_q, active_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] word_q;
  logic              scl_d_q;
  logic              scl_fall;
  logic              idx_en, word_en;

  assign scl_fall = scl_d_q & ~scl_s;
  assign done     = active_q & scl_fall & ~abort & (idx_q == IDX_LAST);

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    word_en  = 1'b0;
    if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
      idx_en   = 1'b1;
      word_en  = 1'b1;
    end else if (abort) begin
      active_d = 1'b0;
    end else if (active_q && scl_fall) begin
      idx_d  = idx_q + 1'b1;
      idx_en = 1'b1;
      if (idx_q == IDX_LAST) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      active_q <= 1'b0;
      scl_d_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      scl_d_q  <= scl_s;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      word_q <= '0;
    else if (word_en) word_q <= word_in;
  end

  assign active  = active_q;
  assign bit_out = active_q & word_q[idx_q];

  // R3 R10
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (active_q && !scl_fall && !start && !abort) |=> ($stable(idx_q) && $stable(word_q)));

  // R4
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !active_q);
endmodule

// File: rtl/atr_streamer.sv
module atr_streamer
  import atr_pkg::*;
#(
  parameter int unsigned WORD_W      = ATR_WORD_W,
  parameter int unsigned SYNC_STAGES = ATR_SYNC_STG,
  parameter int unsigned RST_MAX_CYC = ATR_RST_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_rst,
  input  logic              cs_n,
  input  logic              scl,
  input  logic              wr_busy,
  input  logic [WORD_W-1:0] atr_word,
  output logic              sda_o,
  output logic              sda_oe,
  output logic              atr_own
);
  localparam int unsigned IN_W = 4;

  logic            rst_sn;
  logic [IN_W-1:0] pins_raw, pins_s;
  logic            rst_s, cs_s, scl_s, busy_s;
  logic            start, done, active;

  atr_rstsync u_rstsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign pins_raw = {busy_s_in(wr_busy), scl, cs_n, card_rst};

  function automatic logic busy_s_in(input logic b);
    return b;
  endfunction

  atr_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .d       (pins_raw),
    .rst_val (4'b0010),
    .q       (pins_s)
  );

  assign rst_s  = pins_s[0];
  assign cs_s   = pins_s[1];
  assign scl_s  = pins_s[2];
  assign busy_s = pins_s[3];

  atr_seq #(.RST_MAX_CYC(RST_MAX_CYC)) u_seq (
    .clk    (clk),
    .rst_sn (rst_sn),
    .rst_s  (rst_s),
    .cs_s   (cs_s),
    .busy_s (busy_s),
    .done   (done),
    .start  (start),
    .own    (atr_own)
  );

  atr_shift #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .scl_s   (scl_s),
    .start   (start),
    .abort   (cs_s),
    .word_in (atr_word),
    .done    (done),
    .active  (active),
    .bit_out (sda_o)
  );

  assign sda_oe = active;

  // R2
  oe_own_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    sda_oe |-> atr_own);

  // R6
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_s |=> !sda_oe);

  // R1
  idle_data_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !sda_oe |-> !sda_o);
endmodule

// File: tb/atr_streamer_tb.sv
module atr_streamer_tb;
  localparam int WORD_W = 32;

  logic              clk;
  logic              rst_n;
  logic              card_rst, cs_n, scl, wr_busy;
  logic [WORD_W-1:0] atr_word;
  logic              sda_o, sda_oe, atr_own;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  atr_streamer u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .card_rst (card_rst),
    .cs_n     (cs_n),
    .scl      (scl),
    .wr_busy  (wr_busy),
    .atr_word (atr_word),
    .sda_o    (sda_o),
    .sda_oe   (sda_oe),
    .atr_own  (atr_own)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scl_fall();
    scl = 1'b1; wait_clk(6);
    scl = 1'b0; wait_clk(8);
  endtask

  task automatic begin_stream(input logic [31:0] w);
    atr_word = w;
    cs_n = 1'b0; wait_clk(8);
    card_rst = 1'b1; wait_clk(10);
    card_rst = 1'b0; wait_clk(8);
  endtask

  task automatic send_bits(input logic [31:0] w, input int from, input int upto, input string req);
    for (int i = from; i <= upto; i++) begin
      chk({req, " oe"}, {31'd0, sda_oe}, 32'd1);
      chk({req, " bit"}, {31'd0, sda_o}, {31'd0, w[i]});
      scl_fall();
    end
  endtask

  task automatic end_cs();
    cs_n = 1'b1; wait_clk(8);
  endtask

  task automatic t_reset();
    chk("R1 oe", {31'd0, sda_oe}, 32'd0);
    chk("R1 own", {31'd0, atr_own}, 32'd0);
  endtask

  task automatic t_basic(input logic [31:0] w);
    atr_word = w;
    cs_n = 1'b0; wait_clk(8);
    card_rst = 1'b1; wait_clk(10);
    chk("R2 own during pulse", {31'd0, atr_own}, 32'd1);
    chk("R2 oe during pulse", {31'd0, sda_oe}, 32'd0);
    card_rst = 1'b0; wait_clk(8);
    chk("R2 first bit", {31'd0, sda_o}, {31'd0, w[0]});
    send_bits(w, 0, 31, "R3");
    chk("R4 oe released", {31'd0, sda_oe}, 32'd0);
    chk("R4 own released", {31'd0, atr_own}, 32'd0);
    scl_fall();
    chk("R4 stays idle", {31'd0, sda_oe}, 32'd0);
    end_cs();
  endtask

  task automatic t_busy();
    atr_word = 32'hFFFF_FFFF;
    cs_n = 1'b0; wr_busy = 1'b1; wait_clk(8);
    card_rst = 1'b1; wait_clk(10);
    chk("R5 own during pulse", {31'd0, atr_own}, 32'd0);
    wr_busy = 1'b0; wait_clk(4);
    card_rst = 1'b0; wait_clk(8);
    chk("R5 oe after fall", {31'd0, sda_oe}, 32'd0);
    scl_fall(); scl_fall();
    chk("R5 oe after scl", {31'd0, sda_oe}, 32'd0);
    chk("R5 own after scl", {31'd0, atr_own}, 32'd0);
    end_cs();
  endtask

  task automatic t_cs_abort();
    logic [31:0] w = 32'hDEAD_BEEF;
    begin_stream(w);
    send_bits(w, 0, 4, "R6 pre");
    cs_n = 1'b1; wait_clk(8);
    chk("R6 oe after cs", {31'd0, sda_oe}, 32'd0);
    chk("R6 own after cs", {31'd0, atr_own}, 32'd0);
    cs_n = 1'b0; wait_clk(8);
    scl_fall(); scl_fall();
    chk("R6 no resume", {31'd0, sda_oe}, 32'd0);
    end_cs();
  endtask

  task automatic t_cs_high();
    atr_word = 32'hFFFF_FFFF;
    cs_n = 1'b1; wait_clk(4);
    card_rst = 1'b1; wait_clk(10);
    card_rst = 1'b0; wait_clk(4);
    cs_n = 1'b0; wait_clk(8);
    chk("R7 deselected pulse", {31'd0, atr_own}, 32'd0);
    end_cs();
    card_rst = 1'b1; wait_clk(8);
    cs_n = 1'b0; wait_clk(8);
    card_rst = 1'b0; wait_clk(8);
    chk("R7 cs fell during pulse oe", {31'd0, sda_oe}, 32'd0);
    chk("R7 cs fell during pulse own", {31'd0, atr_own}, 32'd0);
    end_cs();
  endtask

  task automatic t_long();
    logic [31:0] w = 32'h1234_5679;
    atr_word = 32'hFFFF_FFFF;
    cs_n = 1'b0; wait_clk(8);
    card_rst = 1'b1; wait_clk(300);
    chk("R8 own dropped", {31'd0, atr_own}, 32'd0);
    card_rst = 1'b0; wait_clk(8);
    chk("R8 no answer", {31'd0, sda_oe}, 32'd0);
    end_cs();
    begin_stream(w);
    send_bits(w, 0, 3, "R8 recovery");
    end_cs();
  endtask

  task automatic t_rerise();
    logic [31:0] w = 32'hC0FF_EE11;
    begin_stream(w);
    send_bits(w, 0, 2, "R9 pre");
    card_rst = 1'b1; wait_clk(10);
    card_rst = 1'b0; wait_clk(8);
    send_bits(w, 3, 31, "R9");
    chk("R9 release", {31'd0, atr_own}, 32'd0);
    end_cs();
  endtask

  task automatic t_snap();
    logic [31:0] w = 32'h0F0F_3355;
    begin_stream(w);
    send_bits(w, 0, 1, "R10 pre");
    atr_word = ~w; wait_clk(4);
    send_bits(w, 2, 31, "R10");
    end_cs();
  endtask

  task automatic t_scl_armed();
    logic [31:0] w = 32'hAAAA_5556;
    atr_word = w;
    cs_n = 1'b0; wait_clk(8);
    card_rst = 1'b1; wait_clk(6);
    scl_fall(); scl_fall(); scl_fall();
    card_rst = 1'b0; wait_clk(8);
    send_bits(w, 0, 7, "R11");
    end_cs();
  endtask

  initial begin
    rst_n = 1'b0; card_rst = 1'b0; cs_n = 1'b1; scl = 1'b0; wr_busy = 1'b0;
    atr_word = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(10);
    t_reset();
    t_basic(32'hA5C3_0F96);
    t_basic(32'h8000_0001);
    t_busy();
    t_cs_abort();
    t_cs_high();
    t_long();
    t_rerise();
    t_snap();
    t_scl_armed();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule